// File: doc/BRIEF.md
# Routed External Interrupt Controller

This block gathers a parameterised set of level-sensitive interrupt sources (256 by default) and delivers each one to a chosen core and to a chosen interrupt pin on that core. It has four cores with four pins each by default, so it drives a 4x4 array of pin levels. Each source has three state bits: a raw status bit that follows its input, an enable bit, and a per-core status bit. Software clears the per-core status bit by writing a one. A pin is high while at least one core-status bit of its core belongs to a source that currently routes to that pin.

The target core comes from a per-source map byte. The target pin comes from a map byte that is shared by each group of 32 sources. A byte is read either as a one-hot mask or as a binary number, and two configuration bits pick the form, one for the core map and one for the pin map. When software changes an enable bit or a core map byte, the pending sources that change touches are evaluated again. A pending source whose target core changes leaves its old core and is raised at its new core. The node-type and bounce words are plain storage.

Software reaches the block through a 64-bit word register port. The port has no back-pressure: a request strobe is accepted in every cycle. Read data and an error flag come back registered, in the cycle after the request. All writes replace a whole 64-bit word.

Top module: `ext_irq_router`

## Requirements
- R1: After reset every register reads zero, every pin is low, and `rsp_rdata` and `rsp_err` are zero.
- R2: The raw status bit of source s follows `irq_in[s]`: a rising input sets it and a falling input clears it, one clock later. Raw status is read-only at region 1. Word w holds sources 64w to 64w+63, and source s sits at bit s%64.
- R3: When an input rises, the core-status bit of the routed core is set only if the source's enable bit is 1. Enable bits are in region 2 and use the same word and bit layout as R2. When an input falls, the source's core-status bit is cleared. Core status is read in region 3 at index core*(NUM_SRC/64)+word.
- R4: `pin_o[c*NUM_PIN+p]` is the OR of the core-status bits of core c whose sources resolve to pin p. The pins are combinational from the registered state.
- R5: Core map, one-hot form (config bit 1 = 0). Region 4, word w holds sources 8w to 8w+7, and source 8w+k uses bits 8k+7:8k. The core is the position of the lowest set bit of the byte. A zero byte, or a position of NUM_CORE or more, selects core 0.
- R6: Core map, binary form (config bit 1 = 1). The byte value is the core number, and a value of NUM_CORE or more selects core 0.
- R7: The pin map is region 5. Byte g sits at bits 8g+7:8g and serves sources 32g to 32g+31. With config bit 0 = 0 the byte is decoded as in R5. With config bit 0 = 1 it is decoded as in R6, using NUM_PIN.
- R8: A write of ones to a core-status word clears those bits of that core only. Bits written as zero keep their value, and the cleared sources leave that core's pin OR.
- R9: If an enable bit goes 0 to 1 while raw status is set, the source is raised at its routed core. If it goes 1 to 0 while raw status is set, the source is dropped there.
- R10: If a source's resolved core changes while its raw status is set, the bit is cleared at the old core and, if the source is enabled, set at the new core. If raw status is clear, only the map changes.
- R11: The configuration word is region 0 index 0, with bit 0 for pin binary form, bit 1 for core binary form and bit 2 for global enable. A write stores the written value ANDed with the read-only feature mask at region 0 index 1. A nonzero write while bit 2 is set is rejected: `rsp_err` is 1 and the word keeps its value.
- R12: A write or read outside the decoded ranges gives `rsp_err`=1 and changes no state. The decoded ranges are regions 0 to 7 with their word counts. A write to a read-only word (raw status, feature mask) does the same.
- R13: The node-type words (region 6, NODE_WORDS words) and the bounce words (region 7, NUM_SRC/64 words) read back the value last written and affect nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Level interrupt sources |
| req_valid | input | 1 | Register access strobe, accepted every cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Region in [11:8], word index in [7:0] |
| req_wdata | input | 64 | Write word |
| rsp_rdata | output | 64 | Read word, the cycle after the request |
| rsp_err | output | 1 | Error flag, the cycle after the request |
| pin_o | output | NUM_CORE*NUM_PIN | Pin levels, index core*NUM_PIN+pin |

## Verification
The bench builds the block with its default parameters: 256 sources, four cores, four pins, all three feature bits present and two node-type words. With 256 sources the pin map fills exactly one word, and every core index and pin index is a two-bit code. This puts within reach the out-of-range one-hot positions (bit 4 and up) and the binary values of 4 and more, which must fold to target 0. It also reaches routing across several 64-bit words, and a source that moves to a different core while it is still pending.

// File: rtl/ext_irq_router_pkg.sv
package ext_irq_router_pkg;
  localparam logic [3:0] RG_CFG  = 4'd0;
  localparam logic [3:0] RG_RAW  = 4'd1;
  localparam logic [3:0] RG_EN   = 4'd2;
  localparam logic [3:0] RG_CST  = 4'd3;
  localparam logic [3:0] RG_CMAP = 4'd4;
  localparam logic [3:0] RG_PMAP = 4'd5;
  localparam logic [3:0] RG_NODE = 4'd6;
  localparam logic [3:0] RG_BNC  = 4'd7;

  localparam int CFG_PIN_BIN   = 0;
  localparam int CFG_CORE_BIN  = 1;
  localparam int CFG_GLOBAL_EN = 2;
  localparam int CFG_W         = 3;

  // Turn a map byte into a target index; anything out of range folds to 0.
  function automatic int unsigned decode_target(input logic [7:0] code,
                                                input logic bin_mode,
                                                input int unsigned count);
    int unsigned pos;
    pos = count;
    if (bin_mode) begin
      pos = {24'd0, code};
    end else begin
      for (int i = 7; i >= 0; i--) begin
        if (code[i]) pos = unsigned'(i);
      end
    end
    return (pos < count) ? pos : 0;
  endfunction
endpackage

// File: rtl/ext_irq_router_regs.sv
module ext_irq_router_regs
  import ext_irq_router_pkg::*;
#(
  parameter int NUM_SRC    = 256,
  parameter int NUM_CORE   = 4,
  parameter logic [CFG_W-1:0] FEAT_MASK = 3'b111,
  parameter int NODE_WORDS = 2,
  localparam int SRC_WORDS  = NUM_SRC / 64,
  localparam int CMAP_WORDS = NUM_SRC / 8,
  localparam int PMAP_BYTES = NUM_SRC / 32,
  localparam int PMAP_WORDS = (PMAP_BYTES + 7) / 8,
  localparam int CST_WORDS  = NUM_CORE * SRC_WORDS
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  input  logic                               req_write,
  input  logic [11:0]                        req_addr,
  input  logic [63:0]                        req_wdata,
  input  logic [NUM_SRC-1:0]                 raw_q,
  input  logic [NUM_CORE-1:0][NUM_SRC-1:0]   cst_q,
  output logic [NUM_SRC-1:0]                 en_q,
  output logic [NUM_SRC-1:0]                 en_nx,
  output logic [NUM_SRC-1:0][7:0]            cmap_q,
  output logic [NUM_SRC-1:0][7:0]            cmap_nx,
  output logic [PMAP_WORDS*8-1:0][7:0]       pmap_q,
  output logic [CFG_W-1:0]                   cfg_q,
  output logic [NUM_CORE-1:0][NUM_SRC-1:0]   cst_clr,
  output logic [63:0]                        rsp_rdata,
  output logic                               rsp_err
);
  logic [3:0]  region;
  int unsigned idx;
  logic        in_range, read_only, cfg_reject, wr_ok, bad;
  logic [63:0] rd_val;
  logic [NODE_WORDS-1:0][63:0] node_q;
  logic [SRC_WORDS-1:0][63:0]  bnc_q;

  assign region = req_addr[11:8];
  assign idx    = {24'd0, req_addr[7:0]};

  always_comb begin
    case (region)
      RG_CFG:  in_range = idx < 2;
      RG_RAW:  in_range = idx < SRC_WORDS;
      RG_EN:   in_range = idx < SRC_WORDS;
      RG_CST:  in_range = idx < CST_WORDS;
      RG_CMAP: in_range = idx < CMAP_WORDS;
      RG_PMAP: in_range = idx < PMAP_WORDS;
      RG_NODE: in_range = idx < NODE_WORDS;
      RG_BNC:  in_range = idx < SRC_WORDS;
      default: in_range = 1'b0;
    endcase
  end

  assign read_only  = (region == RG_RAW) || (region == RG_CFG && idx == 1);
  assign cfg_reject = (region == RG_CFG) && (idx == 0) && cfg_q[CFG_GLOBAL_EN] &&
                      (req_wdata != 64'd0);
  assign wr_ok = req_valid && req_write && in_range && !read_only && !cfg_reject;
  assign bad   = req_valid && (!in_range || (req_write && (read_only || cfg_reject)));

  // Post-write views, shared with the per-source slices.
  always_comb begin
    en_nx   = en_q;
    cmap_nx = cmap_q;
    cst_clr = '0;
    if (wr_ok) begin
      for (int w = 0; w < SRC_WORDS; w++) begin
        if (region == RG_EN && idx == unsigned'(w)) en_nx[w*64 +: 64] = req_wdata;
      end
      for (int w = 0; w < CMAP_WORDS; w++) begin
        if (region == RG_CMAP && idx == unsigned'(w)) cmap_nx[w*8 +: 8] = req_wdata;
      end
      for (int c = 0; c < NUM_CORE; c++) begin
        for (int w = 0; w < SRC_WORDS; w++) begin
          if (region == RG_CST && idx == unsigned'(c*SRC_WORDS + w))
            cst_clr[c][w*64 +: 64] = req_wdata;
        end
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (region)
      RG_CFG: rd_val = (idx == 0) ? {61'd0, cfg_q} : {61'd0, FEAT_MASK};
      RG_RAW:
        for (int w = 0; w < SRC_WORDS; w++)
          if (idx == unsigned'(w)) rd_val = raw_q[w*64 +: 64];
      RG_EN:
        for (int w = 0; w < SRC_WORDS; w++)
          if (idx == unsigned'(w)) rd_val = en_q[w*64 +: 64];
      RG_CST:
        for (int c = 0; c < NUM_CORE; c++)
          for (int w = 0; w < SRC_WORDS; w++)
            if (idx == unsigned'(c*SRC_WORDS + w)) rd_val = cst_q[c][w*64 +: 64];
      RG_CMAP:
        for (int w = 0; w < CMAP_WORDS; w++)
          if (idx == unsigned'(w)) rd_val = cmap_q[w*8 +: 8];
      RG_PMAP:
        for (int w = 0; w < PMAP_WORDS; w++)
          if (idx == unsigned'(w)) rd_val = pmap_q[w*8 +: 8];
      RG_NODE:
        for (int w = 0; w < NODE_WORDS; w++)
          if (idx == unsigned'(w)) rd_val = node_q[w];
      RG_BNC:
        for (int w = 0; w < SRC_WORDS; w++)
          if (idx == unsigned'(w)) rd_val = bnc_q[w];
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      cmap_q    <= '0;
      pmap_q    <= '0;
      cfg_q     <= '0;
      node_q    <= '0;
      bnc_q     <= '0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      en_q   <= en_nx;
      cmap_q <= cmap_nx;
      if (wr_ok) begin
        if (region == RG_CFG) cfg_q <= req_wdata[CFG_W-1:0] & FEAT_MASK;
        for (int w = 0; w < PMAP_WORDS; w++)
          if (region == RG_PMAP && idx == unsigned'(w)) pmap_q[w*8 +: 8] <= req_wdata;
        for (int w = 0; w < NODE_WORDS; w++)
          if (region == RG_NODE && idx == unsigned'(w)) node_q[w] <= req_wdata;
        for (int w = 0; w < SRC_WORDS; w++)
          if (region == RG_BNC && idx == unsigned'(w)) bnc_q[w] <= req_wdata;
      end
      rsp_err   <= bad;
      rsp_rdata <= (req_valid && !req_write && !bad) ? rd_val : 64'd0;
    end
  end
endmodule

// File: rtl/ext_irq_router_slice.sv
module ext_irq_router_slice
  import ext_irq_router_pkg::*;
#(
  parameter int NUM_CORE = 4,
  parameter int NUM_PIN  = 4,
  localparam int CW = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
  localparam int PW = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1
) (
  input  logic                irq_lvl,
  input  logic                raw_lvl,
  input  logic                en_cur,
  input  logic                en_nxt,
  input  logic                core_bin,
  input  logic                pin_bin,
  input  logic [7:0]          cmap_cur,
  input  logic [7:0]          cmap_nxt,
  input  logic [7:0]          pmap_byte,
  input  logic [NUM_CORE-1:0] st_cur,
  input  logic [NUM_CORE-1:0] st_clr,
  output logic [NUM_CORE-1:0] st_nxt,
  output logic [PW-1:0]       pin_sel
);
  int unsigned c_old, c_new;

  assign c_old   = decode_target(cmap_cur, core_bin, NUM_CORE);
  assign c_new   = decode_target(cmap_nxt, core_bin, NUM_CORE);
  assign pin_sel = PW'(decode_target(pmap_byte, pin_bin, NUM_PIN));

  // Register-write effects first, then the input edge of this cycle.
  always_comb begin
    st_nxt = st_cur & ~st_clr;
    if (raw_lvl) begin
      if (en_nxt && !en_cur) st_nxt[c_old[CW-1:0]] = 1'b1;
      if (!en_nxt && en_cur) st_nxt[c_old[CW-1:0]] = 1'b0;
      if (c_new != c_old) begin
        st_nxt[c_old[CW-1:0]] = 1'b0;
        if (en_nxt) st_nxt[c_new[CW-1:0]] = 1'b1;
      end
    end
    if (raw_lvl && !irq_lvl) st_nxt = '0;
    if (irq_lvl && !raw_lvl && en_nxt) st_nxt[c_new[CW-1:0]] = 1'b1;
  end
endmodule

// File: rtl/ext_irq_router_pin_or.sv
module ext_irq_router_pin_or #(
  parameter int NUM_SRC  = 256,
  parameter int NUM_CORE = 4,
  parameter int NUM_PIN  = 4,
  localparam int PW = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1
) (
  input  logic [NUM_CORE-1:0][NUM_SRC-1:0] cst_q,
  input  logic [NUM_SRC-1:0][PW-1:0]       pin_sel,
  output logic [NUM_CORE*NUM_PIN-1:0]      pin_o
);
  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    logic [NUM_SRC-1:0] hit;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign hit[s] = (pin_sel[s] == PW'(p));
    end
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      assign pin_o[c*NUM_PIN + p] = |(cst_q[c] & hit);
    end
  end
endmodule

// File: rtl/ext_irq_router.sv
module ext_irq_router
  import ext_irq_router_pkg::*;
#(
  parameter int NUM_SRC    = 256,
  parameter int NUM_CORE   = 4,
  parameter int NUM_PIN    = 4,
  parameter logic [2:0] FEAT_MASK = 3'b111,
  parameter int NODE_WORDS = 2,
  localparam int PW = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1,
  localparam int PMAP_WORDS = (NUM_SRC / 32 + 7) / 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            irq_in,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [11:0]                   req_addr,
  input  logic [63:0]                   req_wdata,
  output logic [63:0]                   rsp_rdata,
  output logic                          rsp_err,
  output logic [NUM_CORE*NUM_PIN-1:0]   pin_o
);
  logic [NUM_SRC-1:0]               raw_q;
  logic [NUM_CORE-1:0][NUM_SRC-1:0] cst_q, cst_nx, cst_clr;
  logic [NUM_SRC-1:0]               en_q, en_nx;
  logic [NUM_SRC-1:0][7:0]          cmap_q, cmap_nx;
  logic [PMAP_WORDS*8-1:0][7:0]     pmap_q;
  logic [CFG_W-1:0]                 cfg_q;
  logic [NUM_SRC-1:0][PW-1:0]       pin_sel;

  ext_irq_router_regs #(
    .NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .FEAT_MASK(FEAT_MASK), .NODE_WORDS(NODE_WORDS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .raw_q(raw_q), .cst_q(cst_q),
    .en_q(en_q), .en_nx(en_nx), .cmap_q(cmap_q), .cmap_nx(cmap_nx),
    .pmap_q(pmap_q), .cfg_q(cfg_q), .cst_clr(cst_clr),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_slice
    logic [NUM_CORE-1:0] col_cur, col_clr, col_nxt;
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_col
      assign col_cur[c]   = cst_q[c][s];
      assign col_clr[c]   = cst_clr[c][s];
      assign cst_nx[c][s] = col_nxt[c];
    end
    ext_irq_router_slice #(.NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_slice (
      .irq_lvl(irq_in[s]), .raw_lvl(raw_q[s]),
      .en_cur(en_q[s]), .en_nxt(en_nx[s]),
      .core_bin(cfg_q[CFG_CORE_BIN]), .pin_bin(cfg_q[CFG_PIN_BIN]),
      .cmap_cur(cmap_q[s]), .cmap_nxt(cmap_nx[s]), .pmap_byte(pmap_q[s/32]),
      .st_cur(col_cur), .st_clr(col_clr), .st_nxt(col_nxt), .pin_sel(pin_sel[s])
    );
  end

  ext_irq_router_pin_or #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_pin_or (
    .cst_q(cst_q), .pin_sel(pin_sel), .pin_o(pin_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      cst_q <= '0;
    end else begin
      raw_q <= irq_in;
      cst_q <= cst_nx;
    end
  end
endmodule

// File: rtl/ext_irq_router_chk.sv
module ext_irq_router_chk #(
  parameter int NUM_SRC  = 256,
  parameter int NUM_CORE = 4,
  parameter int NUM_PIN  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_SRC-1:0]            irq_in,
  input logic [NUM_SRC-1:0]            raw_q,
  input logic [NUM_CORE*NUM_SRC-1:0]   cst_q,
  input logic [2:0]                    cfg_q,
  input logic                          req_valid,
  input logic                          req_write,
  input logic [11:0]                   req_addr,
  input logic [63:0]                   req_wdata,
  input logic                          rsp_err,
  input logic [NUM_CORE*NUM_PIN-1:0]   pin_o
);
  logic [NUM_SRC-1:0] cst_any, dup, fall;

  always_comb begin
    cst_any = '0;
    dup     = '0;
    for (int c = 0; c < NUM_CORE; c++) begin
      dup     = dup | (cst_any & cst_q[c*NUM_SRC +: NUM_SRC]);
      cst_any = cst_any | cst_q[c*NUM_SRC +: NUM_SRC];
    end
  end
  assign fall = raw_q & ~irq_in;

  assert_status_needs_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cst_any & ~raw_q) == '0);

  assert_fall_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall) |=> ((cst_any & $past(fall)) == '0));

  assert_single_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dup == '0);

  assert_pins_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cst_any == '0) |-> (pin_o == '0));

  assert_cfg_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 12'h000 && cfg_q[2] && req_wdata != 64'd0)
    |=> (rsp_err && $stable(cfg_q)));

  assert_bad_region_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[11:8] > 4'd7) |=> rsp_err);
endmodule

bind ext_irq_router ext_irq_router_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .raw_q(raw_q), .cst_q(cst_q),
  .cfg_q(cfg_q), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
  .req_wdata(req_wdata), .rsp_err(rsp_err), .pin_o(pin_o)
);

// File: tb/ext_irq_router_bench.sv
`timescale 1ns/1ps
module ext_irq_router_bench;
  localparam int NS = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_in = '0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [63:0]   req_wdata = '0;
  logic [63:0]   rsp_rdata;
  logic          rsp_err;
  logic [15:0]   pin_o;

  int checks = 0;
  int failures = 0;
  logic [63:0] rd_data;
  logic        last_err;
  logic [63:0] en0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_router u_ext_irq_router (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .pin_o(pin_o)
  );

  function automatic logic [11:0] ra(input logic [3:0] r, input logic [7:0] i);
    return {r, i};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    last_err = rsp_err;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    rd_data = rsp_rdata; last_err = rsp_err;
  endtask

  task automatic irq(input int s, input logic v);
    @(negedge clk);
    irq_in[s] = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 pins", {48'd0, pin_o}, 64'd0);
    chk("R1 rsp", {63'd0, rsp_err}, 64'd0);
    rd(ra(0, 0)); chk("R1 cfg", rd_data, 64'd0);
    rd(ra(2, 0)); chk("R1 enable", rd_data, 64'd0);
    rd(ra(4, 0)); chk("R1 core map", rd_data, 64'd0);
  endtask

  task automatic t_raw();
    irq(5, 1'b1);
    rd(ra(1, 0)); chk("R2 raw set", rd_data, 64'h20);
    chk("R3 disabled no pin", {48'd0, pin_o}, 64'd0);
    rd(ra(3, 0)); chk("R3 disabled no core status", rd_data, 64'd0);
    irq(5, 1'b0);
    rd(ra(1, 0)); chk("R2 raw clear", rd_data, 64'd0);
  endtask

  task automatic t_basic();
    wr(ra(2, 0), 64'h8);
    irq(3, 1'b1);
    chk("R4 core0 pin0", {48'd0, pin_o}, 64'h1);
    rd(ra(3, 0)); chk("R3 core status set", rd_data, 64'h8);
    irq(3, 1'b0);
    chk("R3 fall drops pin", {48'd0, pin_o}, 64'd0);
    rd(ra(3, 0)); chk("R3 fall clears status", rd_data, 64'd0);
  endtask

  task automatic t_core_onehot();
    wr(ra(2, 0), 64'hE00);
    wr(ra(4, 1), 64'h0C10_0400);
    irq(9, 1'b1);  chk("R5 bit2 -> core2", {48'd0, pin_o}, 64'h0100); irq(9, 1'b0);
    irq(10, 1'b1); chk("R5 bit4 -> core0", {48'd0, pin_o}, 64'h0001); irq(10, 1'b0);
    irq(11, 1'b1); chk("R5 lowest bit wins", {48'd0, pin_o}, 64'h0100); irq(11, 1'b0);
  endtask

  task automatic t_pinmap_w1c();
    wr(ra(5, 0), 64'h0800);
    en0 = (64'd1 << 40) | (64'd1 << 41);
    wr(ra(2, 0), en0);
    wr(ra(4, 5), 64'h0202);
    irq(40, 1'b1); irq(41, 1'b1);
    chk("R7 group1 pin3 core1", {48'd0, pin_o}, 64'h0080);
    wr(ra(3, 4), 64'd1 << 40);
    chk("R8 other bit keeps pin", {48'd0, pin_o}, 64'h0080);
    rd(ra(3, 4)); chk("R8 one bit cleared", rd_data, 64'd1 << 41);
    rd(ra(1, 0)); chk("R8 raw untouched", rd_data, en0);
    wr(ra(3, 8), 64'd1 << 41);
    chk("R8 other core write no effect", {48'd0, pin_o}, 64'h0080);
    wr(ra(3, 4), 64'd1 << 41);
    chk("R8 pin low after clear", {48'd0, pin_o}, 64'd0);
    irq(40, 1'b0); irq(41, 1'b0);
  endtask

  task automatic t_enable_toggle();
    irq(50, 1'b1);
    chk("R9 pending while disabled", {48'd0, pin_o}, 64'd0);
    wr(ra(2, 0), en0 | (64'd1 << 50));
    chk("R9 enable raises", {48'd0, pin_o}, 64'h0008);
    rd(ra(3, 0)); chk("R9 status set", rd_data, 64'd1 << 50);
    wr(ra(2, 0), en0);
    chk("R9 disable drops", {48'd0, pin_o}, 64'd0);
    irq(50, 1'b0);
  endtask

  task automatic t_move();
    en0 = en0 | (64'd1 << 60) | (64'd1 << 61);
    wr(ra(2, 0), en0);
    irq(60, 1'b1);
    chk("R10 before move", {48'd0, pin_o}, 64'h0008);
    wr(ra(4, 7), 64'h08_0000_0000);
    chk("R10 moved to core3", {48'd0, pin_o}, 64'h8000);
    rd(ra(3, 12)); chk("R10 new core status", rd_data, 64'd1 << 60);
    rd(ra(3, 0));  chk("R10 old core cleared", rd_data, 64'd0);
    wr(ra(4, 7), 64'h0408_0000_0000);
    chk("R10 idle remap no effect", {48'd0, pin_o}, 64'h8000);
    irq(61, 1'b1);
    chk("R10 remapped idle source", {48'd0, pin_o}, 64'h8800);
    irq(60, 1'b0); irq(61, 1'b0);
    chk("R10 all low", {48'd0, pin_o}, 64'd0);
  endtask

  task automatic t_binary();
    wr(ra(0, 0), 64'h3);
    rd(ra(0, 0)); chk("R11 modes stored", rd_data, 64'h3);
    wr(ra(5, 0), 64'h0100_0800);
    wr(ra(2, 1), (64'd1 << 36) | (64'd1 << 37));
    wr(ra(4, 12), 64'h0902_0000_0000);
    irq(100, 1'b1);
    chk("R6 binary core2 R7 binary pin1", {48'd0, pin_o}, 64'h0200);
    irq(101, 1'b1);
    chk("R6 binary 9 -> core0", {48'd0, pin_o}, 64'h0202);
    irq(100, 1'b0); irq(101, 1'b0);
  endtask

  task automatic t_config();
    wr(ra(0, 0), 64'hFF);
    chk("R11 write accepted", {63'd0, last_err}, 64'd0);
    rd(ra(0, 0)); chk("R11 masked value", rd_data, 64'h7);
    wr(ra(0, 0), 64'h1);
    chk("R11 reject err", {63'd0, last_err}, 64'd1);
    rd(ra(0, 0)); chk("R11 reject keeps", rd_data, 64'h7);
    wr(ra(0, 0), 64'h0);
    rd(ra(0, 0)); chk("R11 zero write allowed", rd_data, 64'h0);
    rd(ra(0, 1)); chk("R11 feature mask", rd_data, 64'h7);
  endtask

  task automatic t_errors();
    wr(ra(9, 0), 64'h1); chk("R12 bad region write", {63'd0, last_err}, 64'd1);
    rd(ra(9, 0));        chk("R12 bad region read", {63'd0, last_err}, 64'd1);
    wr(ra(1, 0), '1);    chk("R12 raw read-only", {63'd0, last_err}, 64'd1);
    rd(ra(1, 0));        chk("R12 raw unchanged", rd_data, 64'd0);
    wr(ra(2, 4), '1);    chk("R12 enable index range", {63'd0, last_err}, 64'd1);
    rd(ra(2, 0));        chk("R12 enable unchanged", rd_data, en0);
    chk("R12 pins unchanged", {48'd0, pin_o}, 64'd0);
  endtask

  task automatic t_storage();
    wr(ra(6, 1), 64'hDEAD_BEEF_0123_4567);
    rd(ra(6, 1)); chk("R13 node word", rd_data, 64'hDEAD_BEEF_0123_4567);
    wr(ra(7, 3), 64'h55);
    rd(ra(7, 3)); chk("R13 bounce word", rd_data, 64'h55);
    chk("R13 no pin effect", {48'd0, pin_o}, 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw();
    t_basic();
    t_core_onehot();
    t_pinmap_w1c();
    t_enable_toggle();
    t_move();
    t_binary();
    t_config();
    t_errors();
    t_storage();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule